// File: doc/BRIEF.md
# Load Lock Scoreboard

This block is the decode-stage interlock of an in-order pipeline that keeps running past data-cache misses. One lock bit is held for every architectural register. Issuing a load sets the bit of the register that the load will fill. Any later instruction in decode that reads or writes a locked register is held back with a stall. Load data comes back out of order through the cache's response queue. Each response carries a tag that names its register. The block sends that data to the register file through a dedicated write port and releases the register's lock.

The pipeline presents the decoded instruction each cycle: a valid flag, a load flag, two source register numbers with use flags, and a destination number with a write flag. It also presents the full flag of the outbound request queue. The block answers in the same cycle. It returns a stall, a push strobe for the request queue, and the request tag. The tag carries the destination register number in its low bits.

Top module: `ldsb_top`

## Requirements
- R1: After reset no register is locked, so a valid non-load instruction with any operands is not stalled.
- R2: A valid instruction whose enabled source operand names a locked register has `stall` high in that cycle.
- R3: A valid instruction whose destination is enabled, or that is a load, and names a locked register has `stall` high in that cycle.
- R4: A valid load that is not stalled raises `req_push` in the same cycle. `req_tag` equals the destination number zero-extended, with the register number in bits [4:0]. From the next cycle that register is locked.
- R5: `wb_en`, `wb_addr` and `wb_data` follow `rsp_valid`, `rsp_tag[4:0]` and `rsp_data` in the same cycle. The named register is unlocked from the next cycle.
- R6: A response that arrives in the same cycle as a decode check releases that register for the check, so it causes no stall. If an issued load locks the same register in that cycle, the register stays locked.
- R7: Register 0 is never locked: a load targeting it pushes a request but leaves no lock.
- R8: While `reqq_full` is high, a valid load is stalled, raises no `req_push` and sets no lock. Non-loads are not affected by `reqq_full`.
- R9: A locked register named by a source or destination whose enable flag is low causes no stall.
- R10: With `dec_valid` low, `stall` and `req_push` stay low and no lock is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction is in decode |
| dec_is_load | input | 1 | The decoded instruction is a load |
| dec_rs1 | input | 5 | First source register number |
| dec_rs1_en | input | 1 | First source is read |
| dec_rs2 | input | 5 | Second source register number |
| dec_rs2_en | input | 1 | Second source is read |
| dec_rd | input | 5 | Destination register number |
| dec_rd_en | input | 1 | Destination is written |
| reqq_full | input | 1 | Outbound request queue cannot take an entry |
| rsp_valid | input | 1 | Response queue head is valid |
| rsp_tag | input | 8 | Response tag, register number in bits [4:0] |
| rsp_data | input | 32 | Returned load data |
| stall | output | 1 | Hold the decoded instruction |
| req_push | output | 1 | Push a read request into the outbound queue |
| req_tag | output | 8 | Tag of the pushed request |
| wb_en | output | 1 | Dedicated register-file write enable |
| wb_addr | output | 5 | Dedicated write port register number |
| wb_data | output | 32 | Dedicated write port data |

## Verification
`stall`, `req_push`, `req_tag` and the write-port outputs depend only on the current inputs and the lock bits, so they are due in the cycle the stimulus is applied. The bench drives inputs just after a falling edge and samples these outputs a few nanoseconds later, before the next rising edge. A lock set or release takes effect at the following rising edge. The bench therefore observes it through the stall seen by the next cycle's decode inputs. In the randomized phase, a cache model with random return latency keeps its own lock image and checks the stall in every cycle.

// File: rtl/ldsb_pkg.sv
package ldsb_pkg;

    localparam int DEF_REG_W  = 5;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_TAG_W  = 8;

    // Reason a decoded instruction is held back; lower value wins ties.
    typedef enum logic [1:0] {
        HZ_NONE  = 2'd0,
        HZ_SRC   = 2'd1,
        HZ_DST   = 2'd2,
        HZ_QFULL = 2'd3
    } hazard_e;

endpackage

// File: rtl/ldsb_lock_table.sv
module ldsb_lock_table #(
    parameter int REG_W = ldsb_pkg::DEF_REG_W,
    localparam int NREGS = 1 << REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_idx,
    output logic [NREGS-1:0] lock_q_o,
    output logic [NREGS-1:0] lock_eff_o
);

    typedef struct packed {
        logic [NREGS-1:0] lock;
    } state_t;

    state_t st_d, st_q;

    logic [NREGS-1:0] set_hit;
    logic [NREGS-1:0] clr_hit;
    logic [NREGS-1:0] nxt_bit;

    assign set_hit = set_en ? (NREGS'(1) << set_idx) : '0;
    assign clr_hit = clr_en ? (NREGS'(1) << clr_idx) : '0;

    // Per-register next value: a new lock beats a release; entry 0 stays free.
    for (genvar i = 0; i < NREGS; i++) begin : g_bit
        if (i == 0) begin : g_zero
            assign nxt_bit[i] = 1'b0;
        end else begin : g_reg
            assign nxt_bit[i] = set_hit[i] | (st_q.lock[i] & ~clr_hit[i]);
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.lock = nxt_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_q_o   = st_q.lock;
    // Locks as seen by decode this cycle: a returning response frees its register now.
    assign lock_eff_o = st_q.lock & ~clr_hit;

endmodule

// File: rtl/ldsb_hazard.sv
module ldsb_hazard
    import ldsb_pkg::*;
#(
    parameter int REG_W = ldsb_pkg::DEF_REG_W,
    localparam int NREGS = 1 << REG_W
) (
    input  logic [NREGS-1:0] lock_eff,
    input  logic             dec_valid,
    input  logic             dec_is_load,
    input  logic [REG_W-1:0] dec_rs1,
    input  logic             dec_rs1_en,
    input  logic [REG_W-1:0] dec_rs2,
    input  logic             dec_rs2_en,
    input  logic [REG_W-1:0] dec_rd,
    input  logic             dec_rd_en,
    input  logic             reqq_full,
    output hazard_e          cause
);

    logic src_hit;
    logic dst_hit;
    logic q_hit;

    assign src_hit = (dec_rs1_en & lock_eff[dec_rs1]) |
                     (dec_rs2_en & lock_eff[dec_rs2]);
    assign dst_hit = (dec_rd_en | dec_is_load) & lock_eff[dec_rd];
    assign q_hit   = dec_is_load & reqq_full;

    always_comb begin
        cause = HZ_NONE;
        if (dec_valid) begin
            if (src_hit) begin
                cause = HZ_SRC;
            end else if (dst_hit) begin
                cause = HZ_DST;
            end else if (q_hit) begin
                cause = HZ_QFULL;
            end
        end
    end

endmodule

// File: rtl/ldsb_top.sv
module ldsb_top
    import ldsb_pkg::*;
#(
    parameter int REG_W  = ldsb_pkg::DEF_REG_W,
    parameter int DATA_W = ldsb_pkg::DEF_DATA_W,
    parameter int TAG_W  = ldsb_pkg::DEF_TAG_W,
    localparam int NREGS = 1 << REG_W,
    localparam int PAD_W = TAG_W - REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic              dec_is_load,
    input  logic [REG_W-1:0]  dec_rs1,
    input  logic              dec_rs1_en,
    input  logic [REG_W-1:0]  dec_rs2,
    input  logic              dec_rs2_en,
    input  logic [REG_W-1:0]  dec_rd,
    input  logic              dec_rd_en,
    input  logic              reqq_full,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              stall,
    output logic              req_push,
    output logic [TAG_W-1:0]  req_tag,
    output logic              wb_en,
    output logic [REG_W-1:0]  wb_addr,
    output logic [DATA_W-1:0] wb_data
);

    logic [NREGS-1:0] lock_vec;
    logic [NREGS-1:0] lock_eff;
    logic [REG_W-1:0] rsp_reg;
    logic             lock_set;
    hazard_e          cause;

    assign rsp_reg  = rsp_tag[REG_W-1:0];

    ldsb_hazard #(.REG_W(REG_W)) hazard_i (
        .lock_eff    (lock_eff),
        .dec_valid   (dec_valid),
        .dec_is_load (dec_is_load),
        .dec_rs1     (dec_rs1),
        .dec_rs1_en  (dec_rs1_en),
        .dec_rs2     (dec_rs2),
        .dec_rs2_en  (dec_rs2_en),
        .dec_rd      (dec_rd),
        .dec_rd_en   (dec_rd_en),
        .reqq_full   (reqq_full),
        .cause       (cause)
    );

    assign stall    = (cause != HZ_NONE);
    assign req_push = dec_valid & dec_is_load & ~stall;
    assign req_tag  = {{PAD_W{1'b0}}, dec_rd};
    assign lock_set = req_push & (dec_rd != '0);

    ldsb_lock_table #(.REG_W(REG_W)) table_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (lock_set),
        .set_idx    (dec_rd),
        .clr_en     (rsp_valid),
        .clr_idx    (rsp_reg),
        .lock_q_o   (lock_vec),
        .lock_eff_o (lock_eff)
    );

    // Dedicated fill port: never arbitrates with the main writeback.
    assign wb_en   = rsp_valid;
    assign wb_addr = rsp_reg;
    assign wb_data = rsp_data;

endmodule

// File: rtl/ldsb_checker.sv
module ldsb_checker #(
    parameter int REG_W = 5,
    parameter int TAG_W = 8,
    localparam int NREGS = 1 << REG_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dec_valid,
    input logic             dec_is_load,
    input logic [REG_W-1:0] dec_rs1,
    input logic             dec_rs1_en,
    input logic [REG_W-1:0] dec_rd,
    input logic             reqq_full,
    input logic             rsp_valid,
    input logic [TAG_W-1:0] rsp_tag,
    input logic             stall,
    input logic             req_push,
    input logic [NREGS-1:0] lock_vec
);

    AST_ZERO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_vec[0]); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!stall && !req_push)); // R10

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_is_load && reqq_full) |-> (stall && !req_push)); // R8

    AST_LOCK_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_push && dec_rd != '0) |=> lock_vec[$past(dec_rd)]); // R4

    AST_LOCK_FREED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !(req_push && dec_rd == rsp_tag[REG_W-1:0]))
        |=> !lock_vec[$past(rsp_tag[REG_W-1:0])]); // R5

    AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_rs1_en && lock_vec[dec_rs1] &&
         !(rsp_valid && rsp_tag[REG_W-1:0] == dec_rs1)) |-> stall); // R2

endmodule

bind ldsb_top ldsb_checker #(.REG_W(REG_W), .TAG_W(TAG_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_valid   (dec_valid),
    .dec_is_load (dec_is_load),
    .dec_rs1     (dec_rs1),
    .dec_rs1_en  (dec_rs1_en),
    .dec_rd      (dec_rd),
    .reqq_full   (reqq_full),
    .rsp_valid   (rsp_valid),
    .rsp_tag     (rsp_tag),
    .stall       (stall),
    .req_push    (req_push),
    .lock_vec    (lock_vec)
);

// File: tb/ldsb_top_tb_top.sv
`timescale 1ns/1ps
module ldsb_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        dec_valid, dec_is_load, dec_rs1_en, dec_rs2_en, dec_rd_en;
    logic [4:0]  dec_rs1, dec_rs2, dec_rd;
    logic        reqq_full, rsp_valid;
    logic [7:0]  rsp_tag;
    logic [31:0] rsp_data;
    logic        stall, req_push, wb_en;
    logic [7:0]  req_tag;
    logic [4:0]  wb_addr;
    logic [31:0] wb_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ldsb_top dut_i (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_is_load(dec_is_load),
        .dec_rs1(dec_rs1), .dec_rs1_en(dec_rs1_en), .dec_rs2(dec_rs2),
        .dec_rs2_en(dec_rs2_en), .dec_rd(dec_rd), .dec_rd_en(dec_rd_en),
        .reqq_full(reqq_full), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
        .rsp_data(rsp_data), .stall(stall), .req_push(req_push), .req_tag(req_tag),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    typedef struct packed {
        logic       v;
        logic       ld;
        logic [4:0] rd;
        logic [4:0] rs;
        logic       full;
        logic       rv;
        logic [4:0] rr;
        logic       es;
        logic       ep;
    } vec_t;

    // Walked in order; lock state carries from one row to the next.
    localparam vec_t VECS [16] = '{
        '{1'b1, 1'b0, 5'd3, 5'd4, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0}, // R1 fresh
        '{1'b1, 1'b1, 5'd5, 5'd1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1}, // R4 lock 5
        '{1'b1, 1'b0, 5'd6, 5'd5, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0}, // R2 read 5
        '{1'b1, 1'b0, 5'd5, 5'd2, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0}, // R3 write 5
        '{1'b1, 1'b0, 5'd6, 5'd5, 1'b0, 1'b1, 5'd5, 1'b0, 1'b0}, // R6 bypass
        '{1'b1, 1'b0, 5'd7, 5'd5, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0}, // R5 freed
        '{1'b1, 1'b1, 5'd0, 5'd1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1}, // R7 load r0
        '{1'b1, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0}, // R7 r0 free
        '{1'b1, 1'b1, 5'd9, 5'd1, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0}, // R8 full
        '{1'b1, 1'b0, 5'd2, 5'd9, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0}, // R8 no lock
        '{1'b0, 1'b1, 5'd9, 5'd9, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0}, // R10 idle
        '{1'b1, 1'b1, 5'd9, 5'd9, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1}, // R10 no lock
        '{1'b1, 1'b1, 5'd9, 5'd1, 1'b0, 1'b1, 5'd9, 1'b0, 1'b1}, // R6 set+clr
        '{1'b1, 1'b0, 5'd1, 5'd9, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0}, // R6 kept
        '{1'b1, 1'b0, 5'd1, 5'd2, 1'b0, 1'b1, 5'd9, 1'b0, 1'b0}, // R5 release
        '{1'b1, 1'b0, 5'd1, 5'd9, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0}  // R5 freed
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic ld, input logic [4:0] rd,
                         input logic rd_en, input logic [4:0] rs1,
                         input logic rs1_en, input logic [4:0] rs2,
                         input logic rs2_en, input logic full,
                         input logic rv, input logic [4:0] rr);
        dec_valid = v;  dec_is_load = ld; dec_rd = rd;  dec_rd_en = rd_en;
        dec_rs1 = rs1;  dec_rs1_en = rs1_en; dec_rs2 = rs2; dec_rs2_en = rs2_en;
        reqq_full = full; rsp_valid = rv; rsp_tag = {3'b000, rr};
        rsp_data = 32'hC0DE_0000 | {27'd0, rr};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] lk;
        int          cnt [32];
        rst_n = 1'b0;
        do_reset();

        // Table phase.
        for (int i = 0; i < 16; i++) begin
            vec_t t;
            t = VECS[i];
            @(negedge clk);
            drive(t.v, t.ld, t.rd, 1'b1, t.rs, 1'b1, 5'd0, 1'b0, t.full, t.rv, t.rr);
            #2;
            chk(stall == t.es, $sformatf("R2/R3 row %0d stall", i), 32'(stall), 32'(t.es));
            chk(req_push == t.ep, $sformatf("R4 row %0d push", i), 32'(req_push), 32'(t.ep));
            if (t.ep)
                chk(req_tag == {3'b000, t.rd}, "R4 req_tag", 32'(req_tag), 32'(t.rd));
            chk(wb_en == t.rv, "R5 wb_en", 32'(wb_en), 32'(t.rv));
            if (t.rv) begin
                chk(wb_addr == t.rr, "R5 wb_addr", 32'(wb_addr), 32'(t.rr));
                chk(wb_data == (32'hC0DE_0000 | {27'd0, t.rr}), "R5 wb_data",
                    wb_data, 32'hC0DE_0000 | {27'd0, t.rr});
            end
        end

        // R9: disabled operands naming a locked register are ignored.
        @(negedge clk);
        drive(1'b1, 1'b1, 5'd10, 1'b1, 5'd1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0);
        @(negedge clk);
        drive(1'b1, 1'b0, 5'd10, 1'b0, 5'd10, 1'b0, 5'd10, 1'b0, 1'b0, 1'b0, 5'd0);
        #2;
        chk(stall == 1'b0, "R9 disabled operands", 32'(stall), 32'd0);
        @(negedge clk);
        drive(1'b1, 1'b0, 5'd3, 1'b1, 5'd1, 1'b1, 5'd10, 1'b1, 1'b0, 1'b0, 5'd0);
        #2;
        chk(stall == 1'b1, "R2 second source locked", 32'(stall), 32'd1);

        // R8: a full queue does not hold a non-load.
        @(negedge clk);
        drive(1'b1, 1'b0, 5'd4, 1'b1, 5'd2, 1'b1, 5'd3, 1'b1, 1'b1, 1'b0, 5'd0);
        #2;
        chk(stall == 1'b0, "R8 non-load with full queue", 32'(stall), 32'd0);

        // R1: reset drops the lock held on register 10.
        do_reset();
        @(negedge clk);
        drive(1'b1, 1'b0, 5'd10, 1'b1, 5'd10, 1'b1, 5'd10, 1'b1, 1'b0, 1'b0, 5'd0);
        #2;
        chk(stall == 1'b0, "R1 after reset", 32'(stall), 32'd0);

        // Random-latency cache model: stall must match the bench's own lock image.
        lk = '0;
        for (int r = 0; r < 32; r++) cnt[r] = 0;
        for (int c = 0; c < 3000; c++) begin
            logic v, ld, full, rv, es, ep;
            logic [4:0] rd, rs, rr;
            logic [31:0] eff;
            rv = 1'b0;
            rr = 5'd0;
            for (int r = 1; r < 32; r++)
                if (!rv && lk[r] && cnt[r] <= 0) begin
                    rv = 1'b1;
                    rr = 5'(r);
                end
            v    = ($urandom % 4) != 0;
            ld   = ($urandom % 3) == 0;
            full = ($urandom % 8) == 0;
            rd   = 5'($urandom % 12);
            rs   = 5'($urandom % 12);
            @(negedge clk);
            drive(v, ld, rd, 1'b1, rs, 1'b1, 5'd0, 1'b0, full, rv, rr);
            eff = lk;
            if (rv) eff[rr] = 1'b0;
            es = v && (eff[rs] || eff[rd] || (ld && full));
            ep = v && ld && !es;
            #2;
            chk(stall == es, "R2/R3/R6 random stall", 32'(stall), 32'(es));
            chk(req_push == ep, "R4/R8 random push", 32'(req_push), 32'(ep));
            for (int r = 0; r < 32; r++) if (cnt[r] > 0) cnt[r]--;
            if (rv) lk[rr] = 1'b0;
            if (ep && rd != 5'd0) begin
                lk[rd]  = 1'b1;
                cnt[rd] = 1 + int'($urandom % 6);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule